// File: doc/BRIEF.md
# Prescaled Countdown Timer

The block is an 8-bit countdown timer whose main count is stepped down at a slow rate. A free-running prescale counter divides the clock by 256. The main counter loses one unit each time the prescaler wraps. Software or surrounding logic loads a reload value and then pulses a start input. After the loaded number of 256-clock periods has passed, the timer raises a timeout flag and keeps it raised.

The design has a datapath and a separate control state machine. The datapath holds the prescale counter and the main down counter. The state machine has three states: idle, counting and expired. It issues load, prescaler-clear and decrement controls to the datapath. The current main count is visible on an output, so the held and decrementing value can be observed.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: A synchronous active-high reset clears the main count, the prescale counter and the timeout output. After reset the count output reads 0 and timeout reads 0.
- R2: A load pulse copies the 8-bit load value into the main count and clears timeout on the same clock edge. A load while counting aborts the countdown and returns to idle. When load and start are high together, load wins and start is ignored.
- R3: After a load and before a start, the count output holds the loaded value and does not change.
- R4: An accepted start clears the prescaler. The main count then drops by exactly one every 256 clocks. The first drop happens on the 256th clock edge after the start edge.
- R5: With a loaded value N > 0, timeout rises on the clock edge 256·N edges after the start edge. It is low on the edge before that. While timeout is high, the count reads 0.
- R6: A start with a loaded value of 0 raises timeout on the start edge itself.
- R7: Once raised, timeout stays high for any length of time. A start with the count at 0 keeps it high. Only a load or a reset lowers it.
- R8: A start that arrives while the timer is counting is ignored. The prescaler is not cleared and the decrement schedule is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for the reload value |
| load_val_i | input | 8 | Reload value |
| start_i | input | 1 | Start strobe |
| count_o | output | 8 | Current main count |
| timeout_o | output | 1 | Timeout flag, high in the expired state |

## Verification
A prescaler that is off by a few counts, or that is not cleared on start, moves the decrement edge. That shows on count_o within a single 256-clock period, so the bench samples one edge before and one edge after every expected decrement. A control state that leaves counting early or late moves the rising edge of timeout_o by at least one clock. A state that fails to stay expired lets timeout_o drop on the next clock, which the long idle waits after expiry expose.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int CDT_CNT_W = 8;
    localparam int CDT_PRE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } cdt_state_e;

    typedef struct packed {
        logic load;
        logic clr_pre;
        logic dec;
    } cdt_ctrl_s;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int PRE_W = cdt_pkg::CDT_PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic wrap_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    assign wrap_o = (pre_q == PRE_MAX);

    // R4: the prescaler wraps to zero after its top count
    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && !clr_i) |=> (pre_q == '0));

    // R4: the prescaler advances by one when not cleared
    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !wrap_o) |=> (pre_q == $past(pre_q) + 1'b1));
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
    parameter int CNT_W = cdt_pkg::CDT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    assign zero_o  = (cnt_q == '0);

    // R3: the count is held when neither load nor decrement is issued
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !dec_i) |=> $stable(cnt_q));

    // R4: the control never decrements an empty counter
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
    import cdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  logic      start_i,
    input  logic      wrap_i,
    input  logic      last_i,
    input  logic      zero_i,
    output cdt_ctrl_s ctrl_o,
    output logic      timeout_o
);
    cdt_state_e state_q, state_d;
    logic       start_ok;

    assign start_ok = start_i && !load_i && (state_q != ST_COUNT);

    always_comb begin
        ctrl_o.load    = load_i;
        ctrl_o.clr_pre = start_ok;
        ctrl_o.dec     = (state_q == ST_COUNT) && wrap_i && !load_i;
    end

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: if (start_ok) state_d = zero_i ? ST_DONE : ST_COUNT;
                ST_COUNT:         if (ctrl_o.dec && last_i) state_d = ST_DONE;
                default:          state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign timeout_o = (state_q == ST_DONE);

    // R7: timeout is sticky until a load
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (timeout_o && !load_i) |=> timeout_o);

    // R8: a start while counting does not clear the prescaler
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT) |-> !ctrl_o.clr_pre);

    // R2: a load always leaves the timer idle
    assert_load_idle_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = CDT_CNT_W,
    parameter int PRE_W = CDT_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             start_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);
    cdt_ctrl_s ctrl;
    logic      wrap, last, zero;

    cdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ctrl.clr_pre),
        .wrap_o (wrap)
    );

    cdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctrl.load),
        .load_val_i (load_val_i),
        .dec_i      (ctrl.dec),
        .count_o    (count_o),
        .last_o     (last),
        .zero_o     (zero)
    );

    cdt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .start_i   (start_i),
        .wrap_i    (wrap),
        .last_i    (last),
        .zero_i    (zero),
        .ctrl_o    (ctrl),
        .timeout_o (timeout_o)
    );

    // R1: reset clears count and timeout
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !timeout_o));

    // R5: timeout implies an empty count
    assert_zero_at_timeout_R5: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (count_o == '0));

    // R2: a load is visible on the count output after the edge
    assert_load_visible_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_o == $past(load_val_i) && !timeout_o));
endmodule

// File: tb/prescaled_countdown_timer_tb.sv
module prescaled_countdown_timer_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] load_val_i = 8'd0;
    logic       start_i = 1'b0;
    logic [7:0] count_o;
    logic       timeout_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prescaled_countdown_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .start_i    (start_i),
        .count_o    (count_o),
        .timeout_o  (timeout_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        load_i = 1'b1; load_val_i = v;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        chk("R1", "count after reset", count_o, 0);
        chk("R1", "timeout after reset", timeout_o, 0);
    endtask

    task automatic t_hold();
        do_load(8'd5);
        chk("R2", "count after load", count_o, 5);
        wait_n(600);
        chk("R3", "count held before start", count_o, 5);
        chk("R3", "timeout before start", timeout_o, 0);
    endtask

    task automatic t_count_three();
        do_load(8'd3);
        do_start();
        wait_n(255); chk("R4", "count before first drop", count_o, 3);
        wait_n(1);   chk("R4", "count after first drop", count_o, 2);
        wait_n(255); chk("R4", "count before second drop", count_o, 2);
        wait_n(1);   chk("R4", "count after second drop", count_o, 1);
        wait_n(255); chk("R5", "timeout one edge early", timeout_o, 0);
        wait_n(1);   chk("R5", "timeout at 768 edges", timeout_o, 1);
        chk("R5", "count at timeout", count_o, 0);
    endtask

    task automatic t_sticky();
        wait_n(300);
        chk("R7", "timeout held while idle", timeout_o, 1);
        do_start();
        chk("R7", "timeout after start at zero", timeout_o, 1);
        wait_n(5);
        chk("R7", "timeout still held", timeout_o, 1);
        do_load(8'd2);
        chk("R2", "timeout cleared by load", timeout_o, 0);
        chk("R2", "count after reload", count_o, 2);
    endtask

    task automatic t_zero_start();
        do_load(8'd0);
        chk("R6", "timeout after zero load", timeout_o, 0);
        do_start();
        chk("R6", "timeout on start edge", timeout_o, 1);
    endtask

    task automatic t_start_ignored();
        do_load(8'd2);
        do_start();
        wait_n(100);
        do_start();
        wait_n(154);
        chk("R8", "count before drop after restart attempt", count_o, 2);
        wait_n(1);
        chk("R8", "drop on original schedule", count_o, 1);
    endtask

    task automatic t_load_priority();
        do_load(8'd6);
        load_i = 1'b1; load_val_i = 8'd7; start_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        chk("R2", "count with load and start", count_o, 7);
        wait_n(300);
        chk("R2", "start ignored next to load", count_o, 7);
    endtask

    task automatic t_abort();
        do_start();
        wait_n(300);
        chk("R4", "count after one period", count_o, 6);
        do_load(8'd9);
        chk("R2", "count after abort load", count_o, 9);
        wait_n(300);
        chk("R2", "abort leaves timer idle", count_o, 9);
        chk("R2", "no timeout after abort", timeout_o, 0);
    endtask

    task automatic t_reset_mid();
        do_start();
        wait_n(50);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "count after mid reset", count_o, 0);
        chk("R1", "timeout after mid reset", timeout_o, 0);
        wait_n(300);
        chk("R1", "timer idle after reset", count_o, 0);
    endtask

    initial begin
        wait_n(1);
        t_reset();
        t_hold();
        t_count_three();
        t_sticky();
        t_zero_start();
        t_start_ignored();
        t_load_priority();
        t_abort();
        t_reset_mid();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule